// File: doc/BRIEF.md
# Synchronized Six-Channel Counter Group

This block holds six 16-bit up-counters and the registers that control them, all reached through a simple single-cycle register bus. Every counter advances by one on each cycle in which the shared `tick` input is high. A channel can clear itself when its count reaches its own compare value.

Each channel has a synchronization bit. When two or more channels have that bit set, they act as a group. A bus write to the counter of any member loads that value into every member. When a member clears on its own compare match, the clear also reaches every other member that has selected synchronous clearing. A channel whose bit is clear ignores the group, and the group ignores it.

An 8-bit stop register freezes the whole block and fences off the other registers. Its reset value leaves the group stopped, so software must clear the stop bit before the counters run.

Top module: `sync_counter_group`

## Requirements
- R1: After reset, every counter reads 0, every compare register reads 0xFFFF, every clear-source field and the sync register read 0, and the stop register reads 0x3F.
- R2: While stop-register bit 5 is 1, the counters hold their values, bus writes to every register except the stop register are discarded, and reads of every address except the stop register return 0.
- R3: While the group runs and `tick` is 1, each counter that is not being cleared or loaded increments by one at the clock edge and wraps from 0xFFFF to 0.
- R4: A channel whose clear-source field is 3'b001 loads 0 instead of incrementing on a tick edge where its count equals its compare value, so it counts modulo (compare+1).
- R5: A bus write to the counter of a channel whose sync bit is 0 changes that counter only.
- R6: With two or more sync bits set, a bus write to the counter of any synchronized channel loads the written value into every synchronized counter at the same edge, and leaves the other counters alone.
- R7: With two or more sync bits set, a compare-match clear on a synchronized channel clears, at the same edge, every other synchronized channel whose clear-source field is 3'b011. Channels that are unsynchronized or use another code keep counting.
- R8: With exactly one sync bit set, that channel behaves as an independent channel: a write to its counter loads no other counter.
- R9: When a clear and a counter load hit the same channel at the same edge, the channel ends at 0.
- R10: Clear-source codes other than 3'b001 and 3'b011 never clear the counter. Code 3'b011 on an unsynchronized channel never clears it either.
- R11: The stop register is 8 bits wide and bit 5 is the stop control. It can be written and read while the group is stopped. A write that sets the stop bit still lets that cycle's counting happen, and the group freezes from the next edge.
- R12: The word addresses are: counter n at n, compare n at 6+n, clear source n at 12+n (3 bits, upper read bits 0), sync at 18 (6 bits, bit n for channel n), and stop register at 19 (zero-extended on read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for all running counters |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, with bus_sel |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |

## Verification
The bench sweeps compare values on every channel and checks each count against the remainder of the tick count modulo (compare+1). An off-by-one in the match would show up there as a wrong period. The group tests mix synchronized and independent channels with different clear codes. A design that broadcast loads or clears to every channel, or that treated a lone sync bit as a group, would corrupt the values of the bystander channels. A clear and a counter load are forced onto the same edge, and a design that let the load win would leave the written value where 0 belongs. The stop bit is set in a cycle that also ticks, then written while frozen. A design that stopped a cycle early, or that locked the stop register itself, would show the wrong count or never resume.

// File: rtl/sync_counter_group.sv
module sync_counter_group #(
  parameter int NCH = 6,
  parameter int CW = 16,
  parameter int AW = 5,
  parameter int STOP_BIT = 5,
  parameter logic [7:0] STOP_RST = 8'h3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata
);
  localparam int CMP_BASE  = NCH;
  localparam int CSEL_BASE = 2 * NCH;
  localparam int SYNC_ADDR = 3 * NCH;
  localparam int STOP_ADDR = 3 * NCH + 1;
  localparam logic [2:0] CS_MATCH = 3'b001;
  localparam logic [2:0] CS_SYNC  = 3'b011;

  logic [NCH-1:0][CW-1:0] cnt, cmp;
  logic [NCH-1:0][2:0]    csel;
  logic [NCH-1:0]         sync_reg;
  logic [7:0]             mstop;
  logic                   stopped;
  logic                   wr, multi, sync_clr_evt, wr_sync;
  logic [NCH-1:0]         eff_sync, own_clr, cnt_hit, clr, preset;

  assign stopped      = mstop[STOP_BIT];
  assign wr           = bus_sel & bus_we & ~stopped;
  assign multi        = $countones(sync_reg) >= 2;
  assign eff_sync     = multi ? sync_reg : '0;
  assign sync_clr_evt = |(own_clr & eff_sync);
  assign wr_sync      = |(cnt_hit & eff_sync);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign own_clr[i] = tick && csel[i] == CS_MATCH && cnt[i] == cmp[i];
    assign cnt_hit[i] = wr && bus_addr == AW'(i);
    assign clr[i]     = own_clr[i] | (eff_sync[i] & (csel[i] == CS_SYNC) & sync_clr_evt);
    assign preset[i]  = cnt_hit[i] | (wr_sync & eff_sync[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[i]  <= '0;
        cmp[i]  <= '1;
        csel[i] <= '0;
      end else if (!stopped) begin
        if (clr[i])         cnt[i] <= '0;
        else if (preset[i]) cnt[i] <= bus_wdata;
        else if (tick)      cnt[i] <= cnt[i] + 1'b1;
        if (wr && bus_addr == AW'(CMP_BASE + i))  cmp[i]  <= bus_wdata;
        if (wr && bus_addr == AW'(CSEL_BASE + i)) csel[i] <= bus_wdata[2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_reg <= '0;
      mstop    <= STOP_RST;
    end else begin
      if (wr && bus_addr == AW'(SYNC_ADDR)) sync_reg <= bus_wdata[NCH-1:0];
      if (bus_sel && bus_we && bus_addr == AW'(STOP_ADDR)) mstop <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(STOP_ADDR)) bus_rdata = CW'(mstop);
    else if (!stopped) begin
      if (bus_addr == AW'(SYNC_ADDR)) bus_rdata = CW'(sync_reg);
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr == AW'(i))             bus_rdata = cnt[i];
        if (bus_addr == AW'(CMP_BASE + i))  bus_rdata = cmp[i];
        if (bus_addr == AW'(CSEL_BASE + i)) bus_rdata = CW'(csel[i]);
      end
    end
  end
endmodule

// File: rtl/sync_counter_group_chk.sv
module sync_counter_group_chk #(
  parameter int NCH = 6,
  parameter int CW = 16,
  parameter int AW = 5,
  parameter int STOP_ADDR = 19
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   bus_sel,
  input logic                   bus_we,
  input logic [AW-1:0]          bus_addr,
  input logic [CW-1:0]          bus_wdata,
  input logic [CW-1:0]          bus_rdata,
  input logic                   stopped,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] cmp,
  input logic [NCH-1:0][2:0]    csel,
  input logic [NCH-1:0]         sync_reg,
  input logic [7:0]             mstop
);
  logic [NCH-1:0] wr_onehot;
  logic           grp;
  assign wr_onehot = (bus_addr < AW'(NCH)) ? (NCH'(1) << bus_addr) : '0;
  assign grp       = $countones(sync_reg) >= 2;

  AST_RESET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mstop == 8'h3F); // R1

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> $stable(cnt)); // R2

  AST_STOP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && bus_addr != AW'(STOP_ADDR)) |-> bus_rdata == '0); // R2

  for (genvar k = 0; k < NCH; k++) begin : g_k
    AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && tick && csel[k] == 3'b001 && cnt[k] == cmp[k]) |=> cnt[k] == '0); // R4

    AST_SYNC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && bus_sel && bus_we && !tick && grp && |(wr_onehot & sync_reg) && sync_reg[k])
      |=> cnt[k] == $past(bus_wdata)); // R6
  end
endmodule

bind sync_counter_group sync_counter_group_chk #(
  .NCH(NCH), .CW(CW), .AW(AW), .STOP_ADDR(3 * NCH + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .stopped(stopped), .cnt(cnt), .cmp(cmp), .csel(csel),
  .sync_reg(sync_reg), .mstop(mstop)
);

// File: tb/sim_sync_counter_group.sv
`timescale 1ns/1ps
module sim_sync_counter_group;
  logic        clk = 0, rst_n = 0, tick = 0, bus_sel = 0, bus_we = 0;
  logic [4:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  int tests = 0, fails = 0;

  localparam int CMPB = 6, CSB = 12, SYNCA = 18, STOPA = 19;

  sync_counter_group u0 (.*);

  always #2.5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rdchk(input string req, input int a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdchk("R1", STOPA, 16'h003F);
    rdchk("R2", 0, 16'h0000);
    tick_n(5);
    wr(SYNCA, 16'h003F);
    wr(1, 16'h4444);
    wr(STOPA, 16'h001F);
    rdchk("R11", STOPA, 16'h001F);
    for (int i = 0; i < 6; i++) begin
      rdchk("R1", i, 16'h0000);
      rdchk("R1", CMPB + i, 16'hFFFF);
      rdchk("R1", CSB + i, 16'h0000);
    end
    rdchk("R2", SYNCA, 16'h0000);
    // R12 field widths
    wr(CSB + 5, 16'hFFFF);
    rdchk("R12", CSB + 5, 16'h0007);
    wr(CSB + 5, 16'h0000);
    wr(SYNCA, 16'hFFFF);
    rdchk("R12", SYNCA, 16'h003F);
    wr(SYNCA, 16'h0000);
    // R5 independent writes, R3 counting
    for (int i = 0; i < 6; i++) wr(i, 16'(16'h0100 * (i + 1) + i));
    for (int i = 0; i < 6; i++) rdchk("R5", i, 16'(16'h0100 * (i + 1) + i));
    tick_n(9);
    for (int i = 0; i < 6; i++) rdchk("R3", i, 16'(16'h0100 * (i + 1) + i + 9));
    wr(2, 16'hFFFE);
    tick_n(3);
    rdchk("R3", 2, 16'h0001);
    // R4 compare-match sweep
    for (int i = 0; i < 6; i++) begin
      for (int c = 0; c < 5; c++) begin
        automatic int cv = (c == 4) ? 5 : (1 << c) - 1;
        wr(CSB + i, 16'h0001);
        wr(CMPB + i, 16'(cv));
        wr(i, 16'h0000);
        tick_n(21);
        rdchk("R4", i, 16'(21 % (cv + 1)));
      end
      wr(CSB + i, 16'h0000);
    end
    // R10 other codes never clear
    wr(CMPB + 0, 16'h0003);
    wr(CSB + 0, 16'h0002);
    wr(0, 16'h0000);
    tick_n(10);
    rdchk("R10", 0, 16'd10);
    wr(CSB + 0, 16'h0007);
    wr(0, 16'h0000);
    tick_n(10);
    rdchk("R10", 0, 16'd10);
    wr(CSB + 0, 16'h0000);
    // R6 synchronous preset
    for (int i = 0; i < 6; i++) wr(i, 16'(16'h0010 + i));
    wr(SYNCA, 16'b101010);
    wr(3, 16'h0500);
    for (int i = 0; i < 6; i++)
      rdchk("R6", i, (i % 2 == 1) ? 16'h0500 : 16'(16'h0010 + i));
    wr(0, 16'h0077);
    rdchk("R5", 0, 16'h0077);
    rdchk("R5", 1, 16'h0500);
    // R8 single sync bit
    wr(SYNCA, 16'b000100);
    wr(2, 16'h0222);
    rdchk("R8", 2, 16'h0222);
    rdchk("R8", 1, 16'h0500);
    rdchk("R8", 3, 16'h0500);
    // R7 synchronous clear propagation
    wr(SYNCA, 16'h0000);
    wr(CSB + 0, 16'h0001);
    wr(CMPB + 0, 16'h0004);
    wr(CSB + 1, 16'h0003);
    wr(CSB + 4, 16'h0003);
    for (int i = 0; i < 6; i++) wr(i, 16'(100 * i));
    wr(SYNCA, 16'b001011);
    tick_n(5);
    rdchk("R7", 0, 16'd0);
    rdchk("R7", 1, 16'd0);
    rdchk("R7", 2, 16'd205);
    rdchk("R7", 3, 16'd305);
    rdchk("R10", 4, 16'd405);
    rdchk("R7", 5, 16'd505);
    tick_n(2);
    rdchk("R7", 1, 16'd2);
    rdchk("R7", 3, 16'd307);
    // R9 clear beats load
    @(negedge clk); tick = 1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 5'd3; bus_wdata = 16'h0999;
    @(negedge clk);
    tick = 0; bus_sel = 0; bus_we = 0;
    rdchk("R9", 0, 16'd0);
    rdchk("R9", 1, 16'd0);
    rdchk("R6", 3, 16'h0999);
    rdchk("R3", 2, 16'd210);
    rdchk("R10", 4, 16'd410);
    // R11 stop takes effect after the write cycle
    @(negedge clk);
    tick = 1; bus_sel = 1; bus_we = 1; bus_addr = 5'(STOPA); bus_wdata = 16'h0020;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    repeat (3) @(negedge clk);
    tick = 0;
    rdchk("R11", STOPA, 16'h0020);
    rdchk("R2", 2, 16'h0000);
    wr(2, 16'h7777);
    wr(STOPA, 16'h0000);
    rdchk("R11", 2, 16'd211);
    rdchk("R2", 5, 16'd511);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule